// File: doc/BRIEF.md
# Dual-Prescaler PWM Channel Generator

The block drives one pulse-width-modulated output. Its time base is a quantum: the input clock is first divided by a linear factor and then by a power of two. An 8-bit period counter advances once per quantum and wraps after a programmable number of quanta. The output is active inside a window. The window opens at a programmable rise point and closes at a programmable fall point. When the two points are equal, the output is active for the whole period.

Software-facing logic writes two words, each with its own write strobe. The control word holds the divider fields and four mode bits: run, pin gate, inversion and sync bypass. The duty word holds the rise point, the fall point and the period length. The divider fields and the whole duty word are double-buffered. They normally move into the working copy at a period boundary. They move at once while the channel is stopped or when sync bypass is set. The mode bits act on the cycle after their write. A one-cycle strobe marks the first clock of every period.

Top module: `pwmq_channel`

## Requirements
- R1: One quantum lasts (lin + 1) << shift clocks. lin is control word bits [7:0] and shift is control word bits [11:8].
- R2: A period lasts (per + 1) quanta, with per in duty word bits [23:16]. `periodStart` is high for exactly the first clock of every period.
- R3: The output is active while the period count c satisfies rise <= c < fall. The window wraps (c >= rise or c < fall) when rise > fall. rise is duty word bits [7:0] and fall is bits [15:8].
- R4: When rise equals fall, the output is active in every cycle of the period.
- R5: While run (control bit 12) is low, the counters are held at zero and the output is inactive. On the first cycle after run is written high, `periodStart` is high and a full-length period begins.
- R6: While the pin gate (control bit 13) is low, `pwmOut` shows the inactive level.
- R7: The invert bit (control bit 14) swaps the active and inactive levels from the cycle after its write, without waiting for a boundary. With inversion the inactive level is 1.
- R8: With sync bypass (control bit 15) low and the channel running, a new duty word or new divider fields take effect only from the next period start.
- R9: With sync bypass high, or with run low, a new duty word or new divider fields take effect from the cycle after the write.
- R10: Writing run low mid-period drives the output inactive on the next cycle, without finishing the period.
- R11: After reset, `pwmOut` and `periodStart` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlWord | input | 16 | Divider fields and mode bits |
| dutyWe | input | 1 | Write strobe for the duty word |
| dutyWord | input | 24 | Rise point, fall point and period length |
| pwmOut | output | 1 | PWM output level |
| periodStart | output | 1 | High in the first clock of each period |

## Verification
The embedded properties check, on every cycle, that the pin gate and a stopped channel force the inactive level, and that equal points give a fully active output. They also check that both counters wrap after their terminal counts and are held at zero while stopped. Finally, they check that with sync active the working settings change only at a period wrap, and that with sync bypass they always match the latest written words. Only the bench scenarios can show the measured period length and active-cycle count for a divider setting, and that a write in mid-period delays its effect to the next boundary. The same holds for the first-period length after enabling and the timing of inversion and disable relative to a write.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int LIN_W     = 8;
  localparam int SHIFT_W   = 4;
  localparam int CNT_W     = 8;
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
  localparam int PRE_W     = LIN_W + MAX_SHIFT + 1;
  localparam int CTRL_W    = LIN_W + SHIFT_W + 4;
  localparam int DUTY_W    = 3 * CNT_W;

  // control word: mode bits on top, divider fields below
  typedef struct packed {
    logic               syncOff;
    logic               invert;
    logic               pinEn;
    logic               clkEn;
    logic [SHIFT_W-1:0] shiftDiv;
    logic [LIN_W-1:0]   linDiv;
  } ctrl_word_t;

  typedef struct packed {
    logic [CNT_W-1:0] periodMax;
    logic [CNT_W-1:0] fallAt;
    logic [CNT_W-1:0] riseAt;
  } duty_word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic quantTick;
    logic quantStart;
    logic pinEn;
    logic invert;
  } strobe_t;
endpackage

// File: rtl/pwmq_ctrl.sv
module pwmq_ctrl
  import pwmq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  ctrl_word_t ctrlWord,
  input  logic       dutyWe,
  input  duty_word_t dutyWord,
  input  logic       atLast,
  output strobe_t    stb,
  output duty_word_t actDuty
);
  ctrl_word_t         ctrlQ, ctrlNext;
  duty_word_t         dutyQ, dutyNext;
  logic [LIN_W-1:0]   actLin;
  logic [SHIFT_W-1:0] actShift;
  logic [PRE_W-1:0]   preCnt, quantLen, quantLast;
  logic               quantTick, wrapTick, loadNow;

  assign ctrlNext  = ctrlWe ? ctrlWord : ctrlQ;
  assign dutyNext  = dutyWe ? dutyWord : dutyQ;
  assign quantLen  = (PRE_W'(actLin) + PRE_W'(1)) << actShift;
  assign quantLast = quantLen - PRE_W'(1);
  // >= keeps the prescaler bounded when a smaller divider lands mid-quantum
  assign quantTick = ctrlQ.clkEn && (preCnt >= quantLast);
  assign wrapTick  = quantTick && atLast;
  assign loadNow   = !ctrlQ.clkEn || ctrlNext.syncOff || wrapTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      dutyQ <= '0;
    end else begin
      ctrlQ <= ctrlNext;
      dutyQ <= dutyNext;
    end
  end

  // working copy of the buffered settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actLin   <= '0;
      actShift <= '0;
      actDuty  <= '0;
    end else if (loadNow) begin
      actLin   <= ctrlNext.linDiv;
      actShift <= ctrlNext.shiftDiv;
      actDuty  <= dutyNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               preCnt <= '0;
    else if (!ctrlQ.clkEn)   preCnt <= '0;
    else if (quantTick)      preCnt <= '0;
    else                     preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    stb.run        = ctrlQ.clkEn;
    stb.quantTick  = quantTick;
    stb.quantStart = (preCnt == '0);
    stb.pinEn      = ctrlQ.pinEn;
    stb.invert     = ctrlQ.invert;
  end

  a_r1_prescale_wrap: assert property (@(posedge clk) disable iff (!rstN)
    quantTick |=> (preCnt == '0));

  a_r5_prescale_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.clkEn |=> (preCnt == '0));

  a_r8_hold_until_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlQ.clkEn) && !ctrlQ.syncOff && !$past(wrapTick))
      |-> ($stable(actDuty) && $stable(actLin) && $stable(actShift)));

  a_r9_bypass_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.syncOff |-> (actDuty == dutyQ && actLin == ctrlQ.linDiv
                       && actShift == ctrlQ.shiftDiv));
endmodule

// File: rtl/pwmq_datapath.sv
module pwmq_datapath
  import pwmq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  duty_word_t actDuty,
  output logic       atLast,
  output logic       pwmOut,
  output logic       periodStart
);
  logic [CNT_W-1:0] perCnt;
  logic             inWindow, driveLevel;

  assign atLast = (perCnt >= actDuty.periodMax);

  always_ff @(posedge clk) begin
    if (!rstN)              perCnt <= '0;
    else if (!stb.run)      perCnt <= '0;
    else if (stb.quantTick) perCnt <= atLast ? '0 : perCnt + CNT_W'(1);
  end

  always_comb begin
    if (actDuty.riseAt == actDuty.fallAt)
      inWindow = 1'b1;
    else if (actDuty.riseAt < actDuty.fallAt)
      inWindow = (perCnt >= actDuty.riseAt) && (perCnt < actDuty.fallAt);
    else
      inWindow = (perCnt >= actDuty.riseAt) || (perCnt < actDuty.fallAt);
  end

  assign driveLevel  = stb.run & inWindow;
  assign pwmOut      = (driveLevel & stb.pinEn) ^ stb.invert;
  assign periodStart = stb.run & stb.quantStart & (perCnt == '0);

  a_r2_period_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && stb.quantTick && atLast) |=> (perCnt == '0));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && stb.quantTick && !atLast) |=> (perCnt == $past(perCnt) + CNT_W'(1)));

  a_r5_count_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (perCnt == '0));
endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel
  import pwmq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              dutyWe,
  input  logic [DUTY_W-1:0] dutyWord,
  output logic              pwmOut,
  output logic              periodStart
);
  strobe_t    stb;
  duty_word_t actDuty;
  logic       atLast;

  pwmq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlWord (ctrl_word_t'(ctrlWord)),
    .dutyWe   (dutyWe),
    .dutyWord (duty_word_t'(dutyWord)),
    .atLast   (atLast),
    .stb      (stb),
    .actDuty  (actDuty)
  );

  pwmq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .actDuty     (actDuty),
    .atLast      (atLast),
    .pwmOut      (pwmOut),
    .periodStart (periodStart)
  );

  a_r6_pin_gate: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pinEn |-> (pwmOut == stb.invert));

  a_r4_full_duty: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && stb.pinEn && actDuty.riseAt == actDuty.fallAt) |-> (pwmOut != stb.invert));

  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |-> (pwmOut == stb.invert && !periodStart));
endmodule

// File: tb/pwmq_channel_tb_top.sv
module pwmq_channel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic        dutyWe = 1'b0;
  logic [23:0] dutyWord = '0;
  logic        pwmOut, periodStart;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  int mLin = 0, mShift = 0, mPer = 0, mPre = 0;
  bit mClk = 0, mPin = 0, mInv = 0, mSync = 0;
  int sLin = 0, sShift = 0, sRise = 0, sFall = 0, sPeriod = 0;
  int aLin = 0, aShift = 0, aRise = 0, aFall = 0, aPeriod = 0;

  always #5 clk = ~clk;

  pwmq_channel dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .dutyWe(dutyWe), .dutyWord(dutyWord), .pwmOut(pwmOut), .periodStart(periodStart)
  );

  function automatic logic [15:0] mkCtrl(int lin, int sh, bit en, bit pin, bit inv, bit so);
    return {so, inv, pin, en, 4'(sh), 8'(lin)};
  endfunction

  function automatic logic [23:0] mkDuty(int rise, int fall, int per);
    return {8'(per), 8'(fall), 8'(rise)};
  endfunction

  function automatic bit expWindow(int r, int f, int c);
    if (r == f) return 1'b1;
    if (r < f)  return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // advance one clock: update the reference at the edge, compare at the falling edge
  task automatic tick();
    int qLen;
    bit qTick, lastC, wrapC, ld;
    int nLin, nShift, nRise, nFall, nPer;
    bit nClk, nPin, nInv, nSync;
    bit expOut, expStart;
    string tag;
    @(posedge clk);
    qLen  = (aLin + 1) << aShift;
    qTick = mClk && (mPre >= qLen - 1);
    lastC = (mPer >= aPeriod);
    wrapC = qTick && lastC;
    nLin = sLin; nShift = sShift; nClk = mClk; nPin = mPin; nInv = mInv; nSync = mSync;
    if (ctrlWe) begin
      nLin = ctrlWord[7:0]; nShift = ctrlWord[11:8]; nClk = ctrlWord[12];
      nPin = ctrlWord[13]; nInv = ctrlWord[14]; nSync = ctrlWord[15];
    end
    nRise = sRise; nFall = sFall; nPer = sPeriod;
    if (dutyWe) begin
      nRise = dutyWord[7:0]; nFall = dutyWord[15:8]; nPer = dutyWord[23:16];
    end
    ld = !mClk || nSync || wrapC;
    if (!mClk) begin mPre = 0; mPer = 0; end
    else if (qTick) begin mPre = 0; mPer = lastC ? 0 : mPer + 1; end
    else mPre = mPre + 1;
    if (ld) begin
      aLin = nLin; aShift = nShift; aRise = nRise; aFall = nFall; aPeriod = nPer;
    end
    sLin = nLin; sShift = nShift; sRise = nRise; sFall = nFall; sPeriod = nPer;
    mClk = nClk; mPin = nPin; mInv = nInv; mSync = nSync;
    @(negedge clk);
    cycles++;
    expOut   = ((mClk && expWindow(aRise, aFall, mPer)) && mPin) ^ mInv;
    expStart = mClk && (mPre == 0) && (mPer == 0);
    if (!mClk) tag = "R5";
    else if (!mPin) tag = "R6";
    else if (aRise == aFall) tag = "R4";
    else tag = "R3";
    check(pwmOut === expOut, tag, int'(pwmOut), int'(expOut));
    check(periodStart === expStart, "R2", int'(periodStart), int'(expStart));
  endtask

  task automatic writeCtrl(logic [15:0] w);
    ctrlWord = w; ctrlWe = 1'b1;
    tick();
    ctrlWe = 1'b0;
  endtask

  task automatic writeDuty(logic [23:0] w);
    dutyWord = w; dutyWe = 1'b1;
    tick();
    dutyWe = 1'b0;
  endtask

  // from a start cycle, count cycles and active cycles up to the next start
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      len++;
      if (pwmOut) hi++;
      tick();
    end while (!periodStart && len < 5000);
  endtask

  always @(negedge clk) begin
    if (!finished && cycles > 150000) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len, hi, seed;
    seed = $urandom(20240517);
    repeat (3) @(negedge clk);
    check(pwmOut === 1'b0, "R11", int'(pwmOut), 0);
    check(periodStart === 1'b0, "R11", int'(periodStart), 0);
    rstN = 1'b1;
    tick();
    check(pwmOut === 1'b0, "R11", int'(pwmOut), 0);

    // R1/R2/R3: quantum 4 clocks, 4 quanta, window counts 0..1
    writeDuty(mkDuty(0, 2, 3));
    writeCtrl(mkCtrl(1, 1, 1, 1, 0, 0));
    check(periodStart === 1'b1, "R5", int'(periodStart), 1);
    measure(len, hi);
    check(len == 16, "R1", len, 16);
    check(hi == 8, "R3", hi, 8);
    measure(len, hi);
    check(len == 16, "R2", len, 16);

    // R8: mid-period duty write waits for the boundary
    repeat (5) tick();
    writeDuty(mkDuty(0, 2, 1));
    measure(len, hi);
    check(len == 10, "R8", len, 10);
    check(hi == 2, "R8", hi, 2);
    measure(len, hi);
    check(len == 8, "R8", len, 8);
    check(hi == 8, "R8", hi, 8);

    // R4: equal points give full duty
    writeDuty(mkDuty(5, 5, 3));
    measure(len, hi);
    measure(len, hi);
    check(len == 16 && hi == 16, "R4", hi, 16);

    // R9: bypass applies at once
    writeCtrl(mkCtrl(1, 1, 1, 1, 0, 1));
    writeDuty(mkDuty(4, 5, 3));
    check(pwmOut === 1'b0, "R9", int'(pwmOut), 0);
    writeDuty(mkDuty(0, 0, 3));
    check(pwmOut === 1'b1, "R9", int'(pwmOut), 1);

    // R7: inversion without waiting
    writeCtrl(mkCtrl(1, 1, 1, 1, 1, 1));
    check(pwmOut === 1'b0, "R7", int'(pwmOut), 0);
    writeCtrl(mkCtrl(1, 1, 1, 1, 0, 1));
    check(pwmOut === 1'b1, "R7", int'(pwmOut), 1);

    // R6: pin gate
    writeCtrl(mkCtrl(1, 1, 1, 0, 0, 1));
    check(pwmOut === 1'b0, "R6", int'(pwmOut), 0);
    writeCtrl(mkCtrl(1, 1, 1, 0, 1, 1));
    check(pwmOut === 1'b1, "R6", int'(pwmOut), 1);

    // R10: disable mid-period
    writeCtrl(mkCtrl(1, 1, 1, 1, 0, 1));
    writeDuty(mkDuty(0, 2, 3));
    len = 0;
    while (!periodStart && len < 100) begin tick(); len++; end
    tick(); tick();
    check(pwmOut === 1'b1, "R10", int'(pwmOut), 1);
    writeCtrl(mkCtrl(1, 1, 0, 1, 0, 1));
    check(pwmOut === 1'b0, "R10", int'(pwmOut), 0);
    check(periodStart === 1'b0, "R10", int'(periodStart), 0);
    repeat (3) begin
      tick();
      check(pwmOut === 1'b0, "R5", int'(pwmOut), 0);
    end

    // random phase checked against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) begin
        ctrlWord = mkCtrl($urandom_range(3), $urandom_range(2),
                          $urandom_range(6) != 0, $urandom_range(6) != 0,
                          $urandom_range(1), $urandom_range(1));
        ctrlWe = 1'b1;
      end
      if ($urandom_range(9) == 0) begin
        dutyWord = mkDuty($urandom_range(7), $urandom_range(7), $urandom_range(7));
        dutyWe = 1'b1;
      end
      tick();
      ctrlWe = 1'b0;
      dutyWe = 1'b0;
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule